// File: doc/BRIEF.md
# Open-Row DRAM Read Sequencer

This block turns read requests into the command stream that a DRAM device expects, and it returns the matching data beats with a tag. Each request carries a bank, a row, a column and an ID. The block keeps one open-row record per bank. The command it issues depends on that record:

- **Idle bank:** the block opens the row and then issues a column read.
- **Different row open:** the block closes the old row, opens the new one, and then reads.
- **Requested row already open:** the block issues the column read alone.

All delays are counted in clock cycles and set by parameters.

Each bank holds at most one pending request. Requests to different banks therefore proceed at the same time. A read in one bank can finish and return its data while another bank is still waiting out its close or open delay. A column read produces a burst of eight words. The burst starts with the requested column and wraps within that column's aligned group of eight. Column reads are spaced so that bursts follow each other on the return port without overlapping.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset every bank is closed. The command port shows code 0 (none), no data beat is valid, and `req_ready_o` is high for every bank. The first command for a request to a bank that has not been touched since reset is an open, never a close.
- R2: A request to a closed bank that is accepted in cycle a produces an open (code 2) in cycle a+2 and a column read (code 3) in cycle a+2+T_RCD.
- R3: A request to a bank holding another row produces, counting from acceptance cycle a, a close (code 1) in cycle a+2, an open in cycle a+2+T_RP and a column read in cycle a+2+T_RP+T_RCD.
- R4: A request whose row is already open in its bank produces only a column read, in cycle a+2.
- R5: The first data beat appears exactly T_CL cycles after the cycle in which the column read shows on the command port.
- R6: The command port carries the bank in 3 bits, the row in 14 bits (on open and read) and the column in 10 bits (on read), unchanged from the request.
- R7: A burst is 8 consecutive valid beats tagged with the request ID. Beat k carries column `{col[9:3], (col[2:0]+k) mod 8}`. `rdata_last_o` is set on the eighth beat only.
- R8: At most one command is issued per cycle. Two column reads are at least 8 cycles apart, so bursts never overlap on the return port. When reads are waiting, the bursts follow one another with no gap.
- R9: A request is accepted only when its target bank has no pending request. Requests to other banks are accepted meanwhile, and a later row hit in another bank may return its data before an earlier miss.
- R10: Each bank tracks its own open row. A read is only issued to the bank's open row, and an open is only issued to a closed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Target bank can take the request |
| req_bank_i | input | 3 | Request bank |
| req_row_i | input | 14 | Request row |
| req_col_i | input | 10 | Request column (critical word) |
| req_id_i | input | 4 | Request tag |
| cmd_op_o | output | 2 | 0 none, 1 close, 2 open, 3 column read |
| cmd_bank_o | output | 3 | Command bank |
| cmd_row_o | output | 14 | Command row |
| cmd_col_o | output | 10 | Command column |
| rdata_valid_o | output | 1 | Data beat valid |
| rdata_id_o | output | 4 | Tag of the beat |
| rdata_col_o | output | 10 | Column of the beat |
| rdata_last_o | output | 1 | Eighth beat of the burst |

## Verification
The checker's properties hold only if the close and open delays stay below 31 cycles, the limit of its saturating counters. They also assume that request fields are looked at only in cycles where valid and ready are both high. The stimulus changes inputs on the falling edge and holds a request for a single accepting cycle. It aims every request at a bank whose state the bench model knows, so each access is a planned hit, miss or conflict. The overlapped case depends on the default delays, where the close plus open time fits within one burst spacing.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_RD   = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/dram_bank_ctl.sv
module dram_bank_ctl import dram_seq_pkg::*; #(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int ID_W  = 4,
  parameter int T_RP  = 2,
  parameter int T_RCD = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             grant_i,
  output logic             pend_o,
  output cmd_op_e          want_o,
  output logic             elig_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [ID_W-1:0]  id_o
);
  localparam int TMAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TW   = $clog2(TMAX + 1);

  logic             pend_q, open_q;
  logic [ROW_W-1:0] open_row_q, row_q;
  logic [COL_W-1:0] col_q;
  logic [ID_W-1:0]  id_q;
  logic [TW-1:0]    tmr_q;

  always_comb begin
    if (!pend_q)                 want_o = CMD_NONE;
    else if (!open_q)            want_o = CMD_ACT;
    else if (open_row_q == row_q) want_o = CMD_RD;
    else                         want_o = CMD_PRE;
  end

  assign elig_o = pend_q && (tmr_q == '0);
  assign pend_o = pend_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign id_o   = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      open_q     <= 1'b0;
      open_row_q <= '0;
      row_q      <= '0;
      col_q      <= '0;
      id_q       <= '0;
      tmr_q      <= '0;
    end else begin
      if (load_i) begin
        pend_q <= 1'b1;
        row_q  <= row_i;
        col_q  <= col_i;
        id_q   <= id_i;
      end
      if (grant_i) begin
        unique case (want_o)
          CMD_PRE: begin
            open_q <= 1'b0;
            tmr_q  <= TW'(T_RP - 1);
          end
          CMD_ACT: begin
            open_q     <= 1'b1;
            open_row_q <= row_q;
            tmr_q      <= TW'(T_RCD - 1);
          end
          CMD_RD: begin
            pend_q <= 1'b0;
            tmr_q  <= '0;
          end
          default: ;
        endcase
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_cmd_arb.sv
module dram_cmd_arb import dram_seq_pkg::*; #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB)
) (
  input  cmd_op_e          want_i [NB],
  input  logic [NB-1:0]    elig_i,
  input  logic             rd_free_i,
  output logic [NB-1:0]    gnt_o,
  output cmd_op_e          op_o,
  output logic [IW-1:0]    idx_o
);
  logic found;

  // reads first to keep the return port busy, then lowest bank
  always_comb begin
    gnt_o = '0;
    op_o  = CMD_NONE;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (!found && elig_i[i] && rd_free_i && want_i[i] == CMD_RD) begin
        found = 1'b1;
        idx_o = IW'(i);
        op_o  = CMD_RD;
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (!found && elig_i[i] && (want_i[i] == CMD_PRE || want_i[i] == CMD_ACT)) begin
        found = 1'b1;
        idx_o = IW'(i);
        op_o  = want_i[i];
      end
    end
    if (found) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/dram_lat_pipe.sv
module dram_lat_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign q_o = d_i;
    end else begin : g_sr
      logic [W-1:0] sr_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < DEPTH; k++) sr_q[k] <= '0;
        end else begin
          sr_q[0] <= d_i;
          for (int k = 1; k < DEPTH; k++) sr_q[k] <= sr_q[k-1];
        end
      end
      assign q_o = sr_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dram_burst_gen.sv
module dram_burst_gen #(
  parameter int COL_W = 10,
  parameter int ID_W  = 4,
  parameter int BURST = 8,
  localparam int BW   = $clog2(BURST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic             act_q;
  logic [BW-1:0]    beat_q;
  logic [COL_W-1:0] base_q;
  logic [ID_W-1:0]  id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      id_q   <= '0;
    end else if (load_i) begin
      act_q  <= 1'b1;
      beat_q <= '0;
      base_q <= col_i;
      id_q   <= id_i;
    end else if (act_q) begin
      if (beat_q == BW'(BURST - 1)) act_q <= 1'b0;
      beat_q <= beat_q + 1'b1;
    end
  end

  // wrap inside the aligned group
  assign col_o   = {base_q[COL_W-1:BW], base_q[BW-1:0] + beat_q};
  assign valid_o = act_q;
  assign id_o    = id_q;
  assign last_o  = act_q && (beat_q == BW'(BURST - 1));
endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq import dram_seq_pkg::*; #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ID_W   = 4,
  parameter int BURST  = 8,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 3,
  parameter int T_CL   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic [1:0]        cmd_op_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              rdata_valid_o,
  output logic [ID_W-1:0]   rdata_id_o,
  output logic [COL_W-1:0]  rdata_col_o,
  output logic              rdata_last_o
);
  localparam int NB = 1 << BANK_W;
  localparam int GW = $clog2(BURST);
  localparam int PW = 1 + ID_W + COL_W;

  logic [NB-1:0]    pend, elig, gnt_vec;
  cmd_op_e          want [NB];
  logic [ROW_W-1:0] prow [NB];
  logic [COL_W-1:0] pcol [NB];
  logic [ID_W-1:0]  pid  [NB];
  logic             accept;

  assign req_ready_o = !pend[req_bank_i];
  assign accept      = req_valid_i && req_ready_o;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      dram_bank_ctl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W), .T_RP(T_RP), .T_RCD(T_RCD)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (accept && (req_bank_i == BANK_W'(g))),
        .row_i   (req_row_i),
        .col_i   (req_col_i),
        .id_i    (req_id_i),
        .grant_i (gnt_vec[g]),
        .pend_o  (pend[g]),
        .want_o  (want[g]),
        .elig_o  (elig[g]),
        .row_o   (prow[g]),
        .col_o   (pcol[g]),
        .id_o    (pid[g])
      );
    end
  endgenerate

  // column-read spacing keeps bursts disjoint on the return port
  logic [GW-1:0]     rd_gap_q;
  logic              rd_free;
  cmd_op_e           gnt_op;
  logic [BANK_W-1:0] gnt_idx;

  assign rd_free = (rd_gap_q == '0);

  dram_cmd_arb #(.NB(NB)) u_arb (
    .want_i    (want),
    .elig_i    (elig),
    .rd_free_i (rd_free),
    .gnt_o     (gnt_vec),
    .op_o      (gnt_op),
    .idx_o     (gnt_idx)
  );

  cmd_op_e           op_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [ID_W-1:0]   id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_gap_q <= '0;
      op_q     <= CMD_NONE;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      id_q     <= '0;
    end else begin
      if (gnt_op == CMD_RD)      rd_gap_q <= GW'(BURST - 1);
      else if (rd_gap_q != '0)   rd_gap_q <= rd_gap_q - 1'b1;
      op_q   <= gnt_op;
      bank_q <= gnt_idx;
      row_q  <= prow[gnt_idx];
      col_q  <= pcol[gnt_idx];
      id_q   <= pid[gnt_idx];
    end
  end

  assign cmd_op_o   = op_q;
  assign cmd_bank_o = bank_q;
  assign cmd_row_o  = row_q;
  assign cmd_col_o  = col_q;

  logic [PW-1:0] lat_d, lat_q;
  assign lat_d = {op_q == CMD_RD, id_q, col_q};

  dram_lat_pipe #(.DEPTH(T_CL - 1), .W(PW)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lat_d),
    .q_o    (lat_q)
  );

  dram_burst_gen #(.COL_W(COL_W), .ID_W(ID_W), .BURST(BURST)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lat_q[PW-1]),
    .col_i   (lat_q[COL_W-1:0]),
    .id_i    (lat_q[COL_W +: ID_W]),
    .valid_o (rdata_valid_o),
    .id_o    (rdata_id_o),
    .col_o   (rdata_col_o),
    .last_o  (rdata_last_o)
  );
endmodule

// File: rtl/dram_rd_seq_chk.sv
module dram_rd_seq_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ID_W   = 4,
  parameter int BURST  = 8,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BANK_W-1:0] req_bank_i,
  input logic [ROW_W-1:0]  req_row_i,
  input logic [COL_W-1:0]  req_col_i,
  input logic [ID_W-1:0]   req_id_i,
  input logic [1:0]        cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic [COL_W-1:0]  cmd_col_o,
  input logic              rdata_valid_o,
  input logic [ID_W-1:0]   rdata_id_o,
  input logic [COL_W-1:0]  rdata_col_o,
  input logic              rdata_last_o
);
  localparam int NB  = 1 << BANK_W;
  localparam int BW  = $clog2(BURST);
  localparam logic [4:0] SAT = 5'd31;

  logic             open_v [NB];
  logic [ROW_W-1:0] open_r [NB];
  logic [4:0]       since_pre [NB];
  logic [4:0]       since_act [NB];
  logic [4:0]       since_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rd <= SAT;
      for (int b = 0; b < NB; b++) begin
        open_v[b]    <= 1'b0;
        open_r[b]    <= '0;
        since_pre[b] <= SAT;
        since_act[b] <= SAT;
      end
    end else begin
      if (cmd_op_o == 2'd3)    since_rd <= 5'd1;
      else if (since_rd != SAT) since_rd <= since_rd + 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (cmd_op_o == 2'd1 && cmd_bank_o == BANK_W'(b)) begin
          open_v[b]    <= 1'b0;
          since_pre[b] <= 5'd1;
        end else if (since_pre[b] != SAT) begin
          since_pre[b] <= since_pre[b] + 1'b1;
        end
        if (cmd_op_o == 2'd2 && cmd_bank_o == BANK_W'(b)) begin
          open_v[b]    <= 1'b1;
          open_r[b]    <= cmd_row_o;
          since_act[b] <= 5'd1;
        end else if (since_act[b] != SAT) begin
          since_act[b] <= since_act[b] + 1'b1;
        end
      end
    end
  end

  // R3
  act_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 2'd2 |-> since_pre[cmd_bank_o] >= 5'(T_RP));

  // R2
  rd_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 2'd3 |-> since_act[cmd_bank_o] >= 5'(T_RCD));

  // R10
  rd_row_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 2'd3 |-> open_v[cmd_bank_o] && open_r[cmd_bank_o] == cmd_row_o);

  // R10
  act_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 2'd2 |-> !open_v[cmd_bank_o]);

  // R8
  rd_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 2'd3 |-> since_rd >= 5'(BURST));

  // R7
  burst_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o && !rdata_last_o |=> rdata_valid_o
      && rdata_id_o == $past(rdata_id_o)
      && rdata_col_o[BW-1:0] == $past(rdata_col_o[BW-1:0]) + BW'(1)
      && rdata_col_o[COL_W-1:BW] == $past(rdata_col_o[COL_W-1:BW]));

  // R7
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_last_o |-> rdata_valid_o);
endmodule

bind dram_rd_seq dram_rd_seq_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W),
  .BURST(BURST), .T_RP(T_RP), .T_RCD(T_RCD)
) u_chk (.*);

// File: tb/sim_dram_rd_seq.sv
module sim_dram_rd_seq;
  localparam int T_RP = 2, T_RCD = 3, T_CL = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  req_id = '0;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        rd_valid, rd_last;
  logic [3:0]  rd_id;
  logic [9:0]  rd_col;

  dram_rd_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_id_i(req_id),
    .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .rdata_valid_o(rd_valid), .rdata_id_o(rd_id), .rdata_col_o(rd_col), .rdata_last_o(rd_last)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // port monitor
  int c_n = 0, d_n = 0;
  int c_cyc [512]; int c_op [512]; int c_bank [512]; int c_row [512]; int c_col [512];
  int d_cyc [512]; int d_id [512]; int d_col [512]; int d_last [512];
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cmd_op != 2'd0 && c_n < 512) begin
        c_cyc[c_n] <= cyc; c_op[c_n] <= int'(cmd_op); c_bank[c_n] <= int'(cmd_bank);
        c_row[c_n] <= int'(cmd_row); c_col[c_n] <= int'(cmd_col);
        c_n <= c_n + 1;
      end
      if (rd_valid && d_n < 512) begin
        d_cyc[d_n] <= cyc; d_id[d_n] <= int'(rd_id); d_col[d_n] <= int'(rd_col);
        d_last[d_n] <= int'(rd_last);
        d_n <= d_n + 1;
      end
    end
  end

  int nv = 0, nf = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nv++;
    if (!ok) begin
      nf++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  bit mopen [8];
  int mrow [8];

  function automatic int wcol(input int c, input int k);
    return (c & 'h3F8) | ((c + k) & 7);
  endfunction

  task automatic run_one(input int b, input int r, input int c, input int id);
    int a, c0, d0, n, t0, trd;
    int eop [3]; int ecy [3];
    c0 = c_n; d0 = d_n;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'(b); req_row = 14'(r); req_col = 10'(c); req_id = 4'(id);
    #1;
    chk(req_ready == 1'b1, "R9", "ready idle bank", int'(req_ready), 1);
    a = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    t0 = a + 2;
    if (!mopen[b]) begin          // R1 R2: closed bank gets open then read
      n = 2; eop[0] = 2; ecy[0] = t0; eop[1] = 3; ecy[1] = t0 + T_RCD;
    end else if (mrow[b] == r) begin  // R4 hit
      n = 1; eop[0] = 3; ecy[0] = t0;
    end else begin                 // R3 conflict
      n = 3; eop[0] = 1; ecy[0] = t0; eop[1] = 2; ecy[1] = t0 + T_RP;
      eop[2] = 3; ecy[2] = t0 + T_RP + T_RCD;
    end
    chk(c_n - c0 == n, "R8", "command count", c_n - c0, n);
    if (c_n - c0 == n) begin
      for (int i = 0; i < n; i++) begin
        chk(c_op[c0+i] == eop[i] && c_cyc[c0+i] == ecy[i],
            n == 1 ? "R4" : (n == 2 ? "R2" : "R3"), "op/cycle", c_op[c0+i]*1000 + c_cyc[c0+i] - a,
            eop[i]*1000 + ecy[i] - a);
        chk(c_bank[c0+i] == b && (eop[i] == 1 || c_row[c0+i] == r) && (eop[i] != 3 || c_col[c0+i] == c),
            "R6", "address fields", c_row[c0+i], r);
      end
    end
    trd = ecy[n-1];
    chk(d_n - d0 == 8, "R7", "beat count", d_n - d0, 8);
    if (d_n - d0 == 8) begin
      chk(d_cyc[d0] == trd + T_CL, "R5", "first beat delay", d_cyc[d0] - trd, T_CL);
      for (int k = 0; k < 8; k++) begin
        chk(d_col[d0+k] == wcol(c, k) && d_id[d0+k] == id && d_last[d0+k] == (k == 7)
            && d_cyc[d0+k] == d_cyc[d0] + k, "R7", "beat", d_col[d0+k], wcol(c, k));
      end
    end
    mopen[b] = 1'b1; mrow[b] = r;
  endtask

  task automatic run_overlap();
    int a, d0, r1, st;
    int eid [3]; int ecol [3];
    d0 = d_n;
    r1 = mrow[1] ^ 'h2AAA;
    eid[0] = 10; eid[1] = 9; eid[2] = 11;
    ecol[0] = 5; ecol[1] = 'h3FF; ecol[2] = 'h12;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'd1; req_row = 14'(r1); req_col = 10'h3FF; req_id = 4'd9;
    #1; a = cyc;
    chk(req_ready == 1'b1, "R9", "accept conflict", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; req_bank = 3'd1; #1;
    chk(req_ready == 1'b0, "R9", "pending bank blocks", int'(req_ready), 0);
    req_valid = 1'b1; req_bank = 3'd2; req_row = 14'(mrow[2]); req_col = 10'd5; req_id = 4'd10; #1;
    chk(req_ready == 1'b1, "R9", "other bank accepts", int'(req_ready), 1);
    @(negedge clk);
    req_bank = 3'd3; req_row = 14'(mrow[3]); req_col = 10'h12; req_id = 4'd11; #1;
    chk(req_ready == 1'b1, "R9", "third bank accepts", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (50) @(negedge clk);
    st = a + 3 + T_CL;
    chk(d_n - d0 == 24, "R8", "overlap beats", d_n - d0, 24);
    if (d_n - d0 == 24) begin
      for (int j = 0; j < 24; j++) begin
        chk(d_cyc[d0+j] == st + j && d_id[d0+j] == eid[j/8]
            && d_col[d0+j] == wcol(ecol[j/8], j % 8) && d_last[d0+j] == (j % 8 == 7),
            "R8", "gapless reordered burst", d_id[d0+j]*10000 + d_cyc[d0+j] - st,
            eid[j/8]*10000 + j);
      end
    end
    mrow[1] = r1;
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog R8 act=%0d exp=done", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", nv + 1, nf + 1);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) begin mopen[b] = 1'b0; mrow[b] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_op == 2'd0, "R1", "cmd idle", int'(cmd_op), 0);
    chk(rd_valid == 1'b0, "R1", "data idle", int'(rd_valid), 0);
    for (int b = 0; b < 8; b++) begin
      req_bank = 3'(b); #1;
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    end
    // sweep: pass 0 miss, 1 hit, 2 conflict, 3 hit; every wrap offset per pass
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        int r, c;
        if (p == 0)      r = (b == 7) ? 'h3FFF : b * 1000 + 3;
        else if (p == 2) r = mrow[b] ^ (b * 37 + 1);
        else             r = mrow[b];
        c = ((b * 97 + p * 211) & 'h3F8) | ((b + p * 3) & 7);
        run_one(b, r, c, (p * 8 + b) & 15);
      end
    end
    run_overlap();
    $display("  == %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end
endmodule